// File: doc/BRIEF.md
# Load-Use Interlock Detection Unit

This block sits between the decode and execute stages of a five-stage in-order integer pipeline. Each cycle it inspects two instruction words: the one held in the decode/execute pipeline register (the producer, now in execute) and the one held in the fetch/decode register (the consumer, now in decode). If the producer is a load whose destination register is read by the consumer, the consumer cannot yet get the loaded value, even with forwarding. The unit then requests a single stall. The word entering execute is turned into a no-op by clearing its opcode field. The fetch/decode register is held and the program counter is not written.

Detection is combinational, so the stall takes effect in the cycle the hazard is seen. A two-state controller (FLOW, HOLD) records that a stall has just been issued. In FLOW the unit follows the detector. Transition DETECT goes from FLOW to HOLD when a hazard is seen, and PASS stays in FLOW otherwise. In HOLD the unit never stalls, because the load has moved on and forwarding now covers it. Transition RESUME returns from HOLD to FLOW unconditionally after one cycle.

Instruction bits are counted here as hardware indices, with bit 31 the most significant. The opcode is [31:26] and the first source is [25:21]. The second register field is [20:16]: it is the destination in immediate format and the second source in register-register format.

Top module: `load_use_guard`

## Requirements
- R1: Opcode classes are encoded as follows:
  - 6'h00: no-op.
  - 6'h01: register-register ALU.
  - [31:29]=3'b100: load.
  - [31:29]=3'b101: store.
  - [31:29]=3'b001: register-immediate ALU.
  - [31:28]=4'b0001: branch.
  - All other opcodes: no register use.
  
  A stall is only ever raised when the execute-stage word is a load.
- R2: When the decode word is a register-register ALU op, a stall is raised if the load's destination field [20:16] equals the consumer's [25:21] or its [20:16].
- R3: When the decode word is a load, store, register-immediate op or branch, a stall is raised only if the load's [20:16] equals the consumer's [25:21]; the consumer's [20:16] is never compared.
- R4: A decode word of the no-op or no-register-use class never causes a stall.
- R5: A load whose destination field [20:16] is zero never causes a stall.
- R6: `idex_nxt_o` has its opcode bits [31:26] forced to zero while stalling, and its bits [25:0] always equal the decode word's bits [25:0]. Without a stall, `idex_nxt_o` equals the decode word unchanged.
- R7: While stalling, `pc_we_o` is low and `ifid_hold_o` is high in the same cycle. Otherwise `pc_we_o` is high and `ifid_hold_o` is low.
- R8: A stall lasts exactly one cycle. In the cycle after a stall, no stall is raised even if the hazard condition still holds at the inputs. Detection resumes in the cycle after that.
- R9: While `rst_n` is low, `stall_o` is low, `pc_we_o` is high and `idex_nxt_o` equals the decode word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| idex_ir_i | input | 32 | Instruction word in the decode/execute register (producer) |
| ifid_ir_i | input | 32 | Instruction word in the fetch/decode register (consumer) |
| stall_o | output | 1 | Load-use stall request for this cycle |
| pc_we_o | output | 1 | Program counter write enable |
| ifid_hold_o | output | 1 | Hold (recirculate) the fetch/decode register |
| idex_nxt_o | output | 32 | Word to load into the decode/execute register |

## Verification
The hardest situation to reach from the ports is the HOLD state with a live hazard still present at the inputs. A real pipeline would already have replaced the producer with a bubble, so normal traffic never shows this case. The bench reaches it by keeping the same hazardous pair of words on the inputs across the clock edge that follows a stall. It checks that the second cycle is suppressed and that the third cycle stalls again. Around that case, the bench sweeps every producer opcode against every consumer opcode, and sweeps every class against all combinations of a small set of register numbers, including register zero.

// File: rtl/lug_pkg.sv
package lug_pkg;

    localparam int IR_W  = 32;
    localparam int OPC_W = 6;
    localparam int REG_W = 5;

    localparam logic [5:0] OPC_NOP   = 6'h00;
    localparam logic [5:0] OPC_RR    = 6'h01;
    localparam logic [2:0] PFX_LOAD  = 3'b100;
    localparam logic [2:0] PFX_STORE = 3'b101;
    localparam logic [2:0] PFX_RI    = 3'b001;
    localparam logic [3:0] PFX_BR    = 4'b0001;

    typedef enum logic [2:0] {
        CLS_NONE   = 3'd0,
        CLS_RR     = 3'd1,
        CLS_LOAD   = 3'd2,
        CLS_STORE  = 3'd3,
        CLS_RI     = 3'd4,
        CLS_BRANCH = 3'd5
    } op_class_e;

    typedef enum logic [0:0] {
        ST_FLOW = 1'b0,
        ST_HOLD = 1'b1
    } gate_state_e;

endpackage

// File: rtl/lug_opclass.sv
module lug_opclass
    import lug_pkg::*;
#(
    parameter int OPC_W = lug_pkg::OPC_W
) (
    input  logic [OPC_W-1:0] opc_i,
    output op_class_e        cls_o
);

    localparam int TOP3 = OPC_W - 1;

    logic [2:0] pfx3;
    logic [3:0] pfx4;

    assign pfx3 = opc_i[TOP3 -: 3];
    assign pfx4 = opc_i[TOP3 -: 4];

    always_comb begin
        if (opc_i == OPC_W'(OPC_NOP)) begin
            cls_o = CLS_NONE;
        end else if (opc_i == OPC_W'(OPC_RR)) begin
            cls_o = CLS_RR;
        end else if (pfx3 == PFX_LOAD) begin
            cls_o = CLS_LOAD;
        end else if (pfx3 == PFX_STORE) begin
            cls_o = CLS_STORE;
        end else if (pfx3 == PFX_RI) begin
            cls_o = CLS_RI;
        end else if (pfx4 == PFX_BR) begin
            cls_o = CLS_BRANCH;
        end else begin
            cls_o = CLS_NONE;
        end
    end

endmodule

// File: rtl/lug_match.sv
module lug_match
    import lug_pkg::*;
#(
    parameter int REG_W = lug_pkg::REG_W,
    parameter int NSRC  = 2
) (
    input  op_class_e                  prod_cls_i,
    input  op_class_e                  cons_cls_i,
    input  logic [REG_W-1:0]           prod_dest_i,
    input  logic [NSRC-1:0][REG_W-1:0] cons_src_i,
    output logic                       hit_o
);

    logic [NSRC-1:0] eq;
    logic [NSRC-1:0] use_src;

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_cmp
            assign eq[g] = (cons_src_i[g] == prod_dest_i);
        end
    endgenerate

    always_comb begin
        use_src = '0;
        unique case (cons_cls_i)
            CLS_RR:     use_src = '1;
            CLS_LOAD,
            CLS_STORE,
            CLS_RI,
            CLS_BRANCH: use_src[0] = 1'b1;
            default:    use_src = '0;
        endcase
    end

    assign hit_o = (prod_cls_i == CLS_LOAD)
                 && (prod_dest_i != '0)
                 && (|(eq & use_src));

endmodule

// File: rtl/lug_fsm.sv
module lug_fsm
    import lug_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hazard_i,
    output logic stall_o,
    output logic pc_we_o,
    output logic hold_o
);

    gate_state_e state_q;
    gate_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FLOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLOW: state_d = hazard_i ? ST_HOLD : ST_FLOW;
            ST_HOLD: state_d = ST_FLOW;
            default: state_d = ST_FLOW;
        endcase
    end

    always_comb begin
        stall_o = 1'b0;
        unique case (state_q)
            ST_FLOW: stall_o = hazard_i & rst_n;
            ST_HOLD: stall_o = 1'b0;
            default: stall_o = 1'b0;
        endcase
        pc_we_o = ~stall_o;
        hold_o  = stall_o;
    end

endmodule

// File: rtl/load_use_guard.sv
module load_use_guard
    import lug_pkg::*;
#(
    parameter int IR_W  = lug_pkg::IR_W,
    parameter int OPC_W = lug_pkg::OPC_W,
    parameter int REG_W = lug_pkg::REG_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IR_W-1:0] idex_ir_i,
    input  logic [IR_W-1:0] ifid_ir_i,
    output logic            stall_o,
    output logic            pc_we_o,
    output logic            ifid_hold_o,
    output logic [IR_W-1:0] idex_nxt_o
);

    localparam int OPC_LSB  = IR_W - OPC_W;
    localparam int SRC0_LSB = OPC_LSB - REG_W;
    localparam int SRC1_LSB = SRC0_LSB - REG_W;
    localparam int NSRC     = 2;

    logic [1:0][IR_W-1:0] words;
    op_class_e [1:0]      cls;

    assign words[0] = idex_ir_i;
    assign words[1] = ifid_ir_i;

    genvar w;
    generate
        for (w = 0; w < 2; w++) begin : g_cls
            lug_opclass #(.OPC_W(OPC_W)) u_cls (
                .opc_i (words[w][OPC_LSB +: OPC_W]),
                .cls_o (cls[w])
            );
        end
    endgenerate

    logic [REG_W-1:0]           prod_dest;
    logic [NSRC-1:0][REG_W-1:0] cons_src;
    logic                       hazard;

    assign prod_dest   = idex_ir_i[SRC1_LSB +: REG_W];
    assign cons_src[0] = ifid_ir_i[SRC0_LSB +: REG_W];
    assign cons_src[1] = ifid_ir_i[SRC1_LSB +: REG_W];

    lug_match #(.REG_W(REG_W), .NSRC(NSRC)) u_match (
        .prod_cls_i  (cls[0]),
        .cons_cls_i  (cls[1]),
        .prod_dest_i (prod_dest),
        .cons_src_i  (cons_src),
        .hit_o       (hazard)
    );

    lug_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hazard_i (hazard),
        .stall_o  (stall_o),
        .pc_we_o  (pc_we_o),
        .hold_o   (ifid_hold_o)
    );

    assign idex_nxt_o = stall_o ? {OPC_W'(OPC_NOP), ifid_ir_i[OPC_LSB-1:0]}
                                : ifid_ir_i;

    logic idex_unused;
    assign idex_unused = ^{idex_ir_i[SRC0_LSB +: REG_W], idex_ir_i[SRC1_LSB-1:0]};

endmodule

// File: rtl/lug_checker.sv
module lug_checker
    import lug_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [IR_W-1:0] idex_ir_i,
    input logic [IR_W-1:0] ifid_ir_i,
    input logic            stall_o,
    input logic            pc_we_o,
    input logic            ifid_hold_o,
    input logic [IR_W-1:0] idex_nxt_o
);

    logic [2:0] p3;
    logic [2:0] c3;
    logic [3:0] c4;
    logic [5:0] copc;
    logic [4:0] pdst;
    logic [4:0] crs;
    logic [4:0] crt;
    logic       cons_rs_only;

    assign p3   = idex_ir_i[31:29];
    assign c3   = ifid_ir_i[31:29];
    assign c4   = ifid_ir_i[31:28];
    assign copc = ifid_ir_i[31:26];
    assign pdst = idex_ir_i[20:16];
    assign crs  = ifid_ir_i[25:21];
    assign crt  = ifid_ir_i[20:16];
    assign cons_rs_only = (c3 == PFX_LOAD) || (c3 == PFX_STORE)
                       || (c3 == PFX_RI) || (c4 == PFX_BR);

    AST_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (p3 != PFX_LOAD) |-> !stall_o); // R1

    AST_RR_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        ((p3 == PFX_LOAD) && (copc == OPC_RR) && (pdst != 5'd0)
         && (pdst == crt) && !$past(stall_o)) |-> stall_o); // R2

    AST_RS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_rs_only && (pdst != crs)) |-> !stall_o); // R3

    AST_NO_USE: assert property (@(posedge clk) disable iff (!rst_n)
        (copc == OPC_NOP) |-> !stall_o); // R4

    AST_ZERO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (pdst == 5'd0) |-> !stall_o); // R5

    AST_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> ((idex_nxt_o[31:26] == 6'd0)
                     && (idex_nxt_o[25:0] == ifid_ir_i[25:0]))); // R6

    AST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_o |-> (idex_nxt_o == ifid_ir_i)); // R6

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we_o != stall_o) && (ifid_hold_o == stall_o)); // R7

    AST_ONE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> !stall_o); // R8

    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!stall_o && pc_we_o); // R9
        end
    end

endmodule

bind load_use_guard lug_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .idex_ir_i   (idex_ir_i),
    .ifid_ir_i   (ifid_ir_i),
    .stall_o     (stall_o),
    .pc_we_o     (pc_we_o),
    .ifid_hold_o (ifid_hold_o),
    .idex_nxt_o  (idex_nxt_o)
);

// File: tb/sim_load_use_guard.sv
`timescale 1ns/1ps
module sim_load_use_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] idex = '0;
    logic [31:0] ifid = '0;
    logic        stall, pc_we, hold;
    logic [31:0] nxt;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    load_use_guard u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .idex_ir_i   (idex),
        .ifid_ir_i   (ifid),
        .stall_o     (stall),
        .pc_we_o     (pc_we),
        .ifid_hold_o (hold),
        .idex_nxt_o  (nxt)
    );

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] a,
                                       input logic [4:0] b, input logic [15:0] lo);
        return {op, a, b, lo};
    endfunction

    function automatic bit is_load(input logic [5:0] op);
        return op[5:3] == 3'b100;
    endfunction

    function automatic bit uses_a(input logic [5:0] op);
        return (op == 6'h01) || (op[5:3] == 3'b100) || (op[5:3] == 3'b101)
            || (op[5:3] == 3'b001) || (op[5:2] == 4'b0001);
    endfunction

    function automatic bit uses_b(input logic [5:0] op);
        return op == 6'h01;
    endfunction

    function automatic bit expect_stall(input logic [31:0] p, input logic [31:0] c);
        logic [4:0] d;
        d = p[20:16];
        return is_load(p[31:26]) && (d != 5'd0)
            && ((uses_a(c[31:26]) && d == c[25:21]) || (uses_b(c[31:26]) && d == c[20:16]));
    endfunction

    task automatic compare(input bit es, input string tag);
        logic [31:0] en;
        en = es ? {6'd0, ifid[25:0]} : ifid;
        n_run++;
        if (stall !== es || pc_we !== !es || hold !== es || nxt !== en) begin
            n_fail++;
            $display("FAIL %s R6 R7: stall=%0b pc_we=%0b hold=%0b nxt=%h expected stall=%0b pc_we=%0b hold=%0b nxt=%h",
                     tag, stall, pc_we, hold, nxt, es, !es, es, en);
        end
    endtask

    task automatic run_vec(input logic [31:0] p, input logic [31:0] c, input string tag);
        @(negedge clk);
        idex = p;
        ifid = c;
        #1;
        compare(expect_stall(p, c), tag);
        @(negedge clk);
        idex = '0;
        ifid = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [5:0] reps [6];
        reps = '{6'h01, 6'h20, 6'h28, 6'h08, 6'h04, 6'h02};

        // R9: hazard present while in reset
        idex = mk(6'h23, 5'd1, 5'd3, 16'h0);
        ifid = mk(6'h01, 5'd3, 5'd3, 16'h5555);
        #3;
        compare(1'b0, "R9 reset");
        @(negedge clk);
        rst_n = 1'b1;
        idex = '0;
        ifid = '0;
        @(negedge clk);

        // R1 R4: every producer opcode against every consumer opcode
        for (int p = 0; p < 64; p++) begin
            for (int c = 0; c < 64; c++) begin
                run_vec(mk(6'(p), 5'd7, 5'd3, 16'h1234),
                        mk(6'(c), 5'd3, 5'd3, 16'h0ABC),
                        is_load(6'(p)) ? "R4 consumer sweep" : "R1 producer sweep");
            end
        end

        // R2 R3 R5: register sweep per consumer class
        foreach (reps[k]) begin
            for (int d = 0; d < 4; d++) begin
                for (int a = 0; a < 4; a++) begin
                    for (int b = 0; b < 4; b++) begin
                        string tg;
                        if (d == 0) tg = "R5 zero dest";
                        else if (reps[k] == 6'h01) tg = "R2 reg-reg";
                        else tg = "R3 rs only";
                        run_vec(mk(6'h23, 5'd9, 5'(d), 16'hFFFF),
                                mk(reps[k], 5'(a), 5'(b), 16'h8001), tg);
                    end
                end
            end
        end

        // R8: hazard held steady across edges
        @(negedge clk);
        idex = mk(6'h21, 5'd2, 5'd6, 16'h0);
        ifid = mk(6'h01, 5'd4, 5'd6, 16'h0F0F);
        #1;
        compare(1'b1, "R8 first cycle");
        @(negedge clk);
        #1;
        compare(1'b0, "R8 suppressed cycle");
        @(negedge clk);
        #1;
        compare(1'b1, "R8 detection resumes");
        @(negedge clk);
        idex = '0;
        ifid = '0;
        @(negedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule